// File: doc/BRIEF.md
# Restoring Array Divider

This block divides an unsigned dividend by an unsigned divisor in a single combinational pass. It is built as a grid of identical subtract-or-pass bit cells. Every row makes one trial subtraction of the divisor from the running partial remainder. If that trial would go below zero, every cell in the row forwards its own input bit instead of its difference, so the remainder is restored inside the row itself and no separate correction stage is needed.

The rows work from the most significant dividend bit downward. Each row takes the remainder left by the row above, shifts it up by one place, and places the next dividend bit in the free low position. Each row also yields one quotient bit, and the bottom row yields the final remainder. The default size is an 8-bit dividend over a 4-bit divisor, which gives an 8-bit quotient and a 4-bit remainder. There are no registers. A zero divisor gets no special treatment: the output it produces is simply whatever the array computes, and that output is fixed and stated below.

Top module: `restoring_divider`

## Requirements
- R1: For a nonzero divisor, `quotientOut` equals the integer part of `dividendIn / divisorIn`.
- R2: For a nonzero divisor, `remainderOut` equals `dividendIn mod divisorIn`, so it is always strictly below the divisor.
- R3: For a nonzero divisor, `quotientOut * divisorIn + remainderOut` equals `dividendIn` exactly.
- R4: When `divisorIn` is zero, `quotientOut` is all ones and `remainderOut` equals the low `DIVISOR_W` bits of `dividendIn`.
- R5: When `divisorIn` is one, `quotientOut` equals `dividendIn` (for example 255 in gives 255 out) and `remainderOut` is zero.
- R6: When `dividendIn` is below a nonzero `divisorIn`, `quotientOut` is zero and `remainderOut` equals `dividendIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dividendIn | input | DIVIDEND_W (8) | Unsigned dividend |
| divisorIn | input | DIVISOR_W (4) | Unsigned divisor |
| quotientOut | output | DIVIDEND_W (8) | Unsigned quotient; bit k comes from the row that handles dividend bit k |
| remainderOut | output | DIVISOR_W (4) | Final partial remainder, taken from the bottom row |

## Verification
The checks in the bound checker assume two things: the operands are two-state values, and they are looked at only after the combinational array has settled. None of them assumes the divisor is nonzero, because the zero-divisor output is fully defined and has its own check. The stimulus keeps to these assumptions. It changes the operands only on a rising clock edge and compares the outputs at the following falling edge. It steps through every dividend and divisor pair, including divisor zero and divisor one, so each check sees both the restore path and the keep-difference path in every row.

// File: rtl/div_arr_pkg.sv
package div_arr_pkg;

  // Strobes from a row's control slice to that row's cells
  typedef struct packed {
    logic passThru;  // 1: cells forward their input bit (trial went negative)
    logic quoBit;    // quotient bit produced by this row
  } rowStrobe_t;

endpackage

// File: rtl/div_csm_cell.sv
// One bit of a trial subtraction with a pass-or-difference output mux.
module div_csm_cell (
  input  logic xBit,
  input  logic yBit,
  input  logic borrowIn,
  input  logic passSel,
  output logic outBit,
  output logic borrowOut
);

  logic diffBit;

  always_comb begin
    diffBit   = xBit ^ yBit ^ borrowIn;
    borrowOut = (~xBit & yBit) | (~xBit & borrowIn) | (yBit & borrowIn);
    outBit    = passSel ? xBit : diffBit;
  end

endmodule

// File: rtl/div_row_ctl.sv
// Turns a row's final borrow into the strobes its cells and the quotient use.
module div_row_ctl
  import div_arr_pkg::*;
(
  input  logic       rowBorrow,
  output rowStrobe_t strobe
);

  always_comb begin
    strobe.passThru = rowBorrow;
    strobe.quoBit   = ~rowBorrow;
  end

endmodule

// File: rtl/div_row.sv
// One trial-subtraction row: W cells on the low bits plus a borrow-only top slot.
module div_row
  import div_arr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         remHi,
  input  logic [W-1:0] remLo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] remOut,
  output logic         quoBit
);

  logic [W:0] borrowChain;
  logic       rowBorrow;
  rowStrobe_t strobe;

  assign borrowChain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    div_csm_cell u_cell (
      .xBit     (remLo[i]),
      .yBit     (divisor[i]),
      .borrowIn (borrowChain[i]),
      .passSel  (strobe.passThru),
      .outBit   (remOut[i]),
      .borrowOut(borrowChain[i+1])
    );
  end

  // Top slot subtracts a zero divisor bit; only its borrow is needed,
  // since a kept result always fits in W bits.
  assign rowBorrow = ~remHi & borrowChain[W];

  div_row_ctl u_ctl (
    .rowBorrow(rowBorrow),
    .strobe   (strobe)
  );

  assign quoBit = strobe.quoBit;

endmodule

// File: rtl/restoring_divider.sv
// Combinational unsigned array divider built from subtract-or-pass rows.
module restoring_divider #(
  parameter int DIVIDEND_W = 8,
  parameter int DIVISOR_W  = 4
) (
  input  logic [DIVIDEND_W-1:0] dividendIn,
  input  logic [DIVISOR_W-1:0]  divisorIn,
  output logic [DIVIDEND_W-1:0] quotientOut,
  output logic [DIVISOR_W-1:0]  remainderOut
);

  localparam int ROWS = DIVIDEND_W;

  logic [DIVISOR_W-1:0] partRem [0:ROWS];

  assign partRem[0] = '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int BIT_IDX = DIVIDEND_W - 1 - r;
    logic [DIVISOR_W-1:0] rowLo;

    if (DIVISOR_W > 1) begin : g_shift
      assign rowLo = {partRem[r][DIVISOR_W-2:0], dividendIn[BIT_IDX]};
    end else begin : g_single
      assign rowLo = dividendIn[BIT_IDX];
    end

    div_row #(.W(DIVISOR_W)) u_row (
      .remHi  (partRem[r][DIVISOR_W-1]),
      .remLo  (rowLo),
      .divisor(divisorIn),
      .remOut (partRem[r+1]),
      .quoBit (quotientOut[BIT_IDX])
    );
  end

  assign remainderOut = partRem[ROWS];

endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int DIVIDEND_W = 8,
  parameter int DIVISOR_W  = 4
) (
  input logic [DIVIDEND_W-1:0] dividendIn,
  input logic [DIVISOR_W-1:0]  divisorIn,
  input logic [DIVIDEND_W-1:0] quotientOut,
  input logic [DIVISOR_W-1:0]  remainderOut
);

  localparam int PW = DIVIDEND_W + DIVISOR_W;

  logic [PW-1:0] rebuilt;
  logic [PW-1:0] dividendExt;

  always_comb begin
    rebuilt     = PW'(quotientOut) * PW'(divisorIn) + PW'(remainderOut);
    dividendExt = PW'(dividendIn);
  end

  always_comb begin
    // R2
    rem_below_div_chk: assert ((divisorIn == '0) || (remainderOut < divisorIn));
    // R3
    rebuild_match_chk: assert ((divisorIn == '0) || (rebuilt == dividendExt));
    // R4
    zero_div_out_chk: assert ((divisorIn != '0) ||
                              ((&quotientOut) && (remainderOut == dividendIn[DIVISOR_W-1:0])));
    // R5
    unit_div_chk: assert ((divisorIn != DIVISOR_W'(1)) ||
                          ((quotientOut == dividendIn) && (remainderOut == '0)));
    // R6
    small_dvd_chk: assert ((divisorIn == '0) || (dividendExt >= PW'(divisorIn)) ||
                           ((quotientOut == '0) && (PW'(remainderOut) == dividendExt)));
  end

endmodule

bind restoring_divider restoring_divider_chk #(
  .DIVIDEND_W(DIVIDEND_W),
  .DIVISOR_W (DIVISOR_W)
) u_chk (
  .dividendIn  (dividendIn),
  .divisorIn   (divisorIn),
  .quotientOut (quotientOut),
  .remainderOut(remainderOut)
);

// File: tb/restoring_divider_tb.sv
`timescale 1ns/1ps
module restoring_divider_tb;

  localparam int NW = 8;
  localparam int DW = 4;

  typedef struct {
    logic [NW-1:0] dvd;
    logic [DW-1:0] dvs;
    logic [NW-1:0] expQ;
    logic [DW-1:0] expR;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0] dividendIn = '0;
  logic [DW-1:0] divisorIn  = '0;
  logic [NW-1:0] quotientOut;
  logic [DW-1:0] remainderOut;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  restoring_divider #(.DIVIDEND_W(NW), .DIVISOR_W(DW)) u_dut (
    .dividendIn  (dividendIn),
    .divisorIn   (divisorIn),
    .quotientOut (quotientOut),
    .remainderOut(remainderOut)
  );

  task automatic drive(input int a, input int b);
    item_t it;
    @(posedge clk);
    dividendIn = NW'(a);
    divisorIn  = DW'(b);
    it.dvd = NW'(a);
    it.dvs = DW'(b);
    if (b == 0) begin
      it.expQ = '1;
      it.expR = DW'(a % (1 << DW));
    end else begin
      it.expQ = NW'(a / b);
      it.expR = DW'(a % b);
    end
    sbq.push_back(it);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s dvd/dvs: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (!rst && sbq.size() > 0) begin
      item_t it;
      int rebuilt;
      it = sbq.pop_front();
      rebuilt = int'(quotientOut) * int'(it.dvs) + int'(remainderOut);
      if (it.dvs != 0) begin
        check(quotientOut == it.expQ, "R1", quotientOut, it.expQ);
        check(remainderOut == it.expR && remainderOut < it.dvs, "R2", remainderOut, it.expR);
        check(rebuilt == int'(it.dvd), "R3", rebuilt, it.dvd);
      end else begin
        check(quotientOut == '1 && remainderOut == it.expR, "R4",
              {quotientOut, remainderOut}, {it.expQ, it.expR});
      end
      if (it.dvs == 1)
        check(quotientOut == it.dvd && remainderOut == 0, "R5", quotientOut, it.dvd);
      if (it.dvs != 0 && int'(it.dvd) < int'(it.dvs))
        check(quotientOut == 0 && int'(remainderOut) == int'(it.dvd), "R6",
              remainderOut, it.dvd);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Corner cases first: R4 zero divisor, R5 unit divisor at the top value, R6 small dividend
    drive(0, 0);
    drive(255, 0);
    drive(255, 1);
    drive(3, 7);
    drive(255, 15);
    // Exhaustive sweep for R1, R2, R3
    for (int a = 0; a < (1 << NW); a++)
      for (int b = 0; b < (1 << DW); b++)
        drive(a, b);
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule